// File: doc/BRIEF.md
# Reconfigurable Region Swap Sequencer

This block runs the full swap of one reconfigurable region of a device under the command of a control processor. A request names which member of a set of mutually exclusive modules should occupy the region. The sequencer first fences the region off from the static logic and tells the neighbouring stream stages to stall. It then reads a per-module entry from a lookup table held at the head of a word-addressed memory image, and feeds that module's configuration words out through a ready/valid port. Finally it holds the region in reset for a set number of cycles and drops the fence.

Each region gets its own instance. The memory port is a plain combinational word read: the address goes out and the data word comes back in the same cycle. A failed lookup (an empty image) leaves the region fenced and in reset until the next request arrives. Requests that land while a swap is under way are discarded, and a sticky flag records them.

Top module: `prr_swap_seq`

## Requirements
- R1: After rst_n is released, iso_en, region_rst, up_stall, dn_stall, busy, done, err, ovr, cfg_valid and mem_rd are all 0.
- R2: A request is accepted when busy is 0. If it names a module that is not the one loaded, iso_en, up_stall and dn_stall go to 1 in the cycle after the request. The first memory read (mem_rd=1) comes one cycle after that. Both stall outputs equal iso_en at all times.
- R3: The table entry for module i sits at word address LUT_BASE+2*i (the image offset) and LUT_BASE+2*i+1 (the length in words). These two words are read on two consecutive cycles, offset first. Only the low ADDR_W bits of each are used.
- R4: Configuration word k (k = 0 .. length-1) is read from address LUT_BASE+offset+k and presented on cfg_data with cfg_valid=1. It is presented in order, and cfg_last=1 only on the final word.
- R5: While cfg_valid=1 and cfg_ready=0, cfg_valid stays 1 and mem_addr stays unchanged into the next cycle. No word is skipped or repeated. cfg_valid is never 1 unless iso_en is 1.
- R6: The cycle after the final word is accepted, region_rst goes to 1. It stays at 1 for exactly RST_CYCLES cycles, and iso_en stays 1 throughout.
- R7: iso_en and the stalls fall one cycle after region_rst falls. In that same cycle done pulses 1 for one cycle. In the next cycle busy is 0.
- R8: A request naming the module already loaded produces done=1 in the next cycle. It raises no iso_en, no mem_rd and no region_rst.
- R9: A table length of zero ends the swap with err=1, iso_en=1, region_rst=1, busy=0 and no cfg_valid. No module then counts as loaded, and a new request restarts the sequence.
- R10: A request while busy=1 does not change the swap in progress. It sets ovr, which stays 1 until rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Swap request strobe |
| req_module | input | IDX_W | Module index to load |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rdata | input | DATA_W | Memory word, same cycle as address |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_ready | input | 1 | Configuration port accepts word |
| cfg_data | output | DATA_W | Configuration word |
| cfg_last | output | 1 | Final word of the image |
| iso_en | output | 1 | Region output boundary disabled |
| region_rst | output | 1 | Reset to the region's logic |
| up_stall | output | 1 | Stall for the producer feeding the region |
| dn_stall | output | 1 | Stall for the consumer fed by the region |
| busy | output | 1 | Swap in progress |
| done | output | 1 | One-cycle swap-complete pulse |
| err | output | 1 | Empty image found, region held |
| ovr | output | 1 | Sticky: request arrived while busy |

## Verification
Two functions can meet in one cycle: acceptance of the final configuration word, and a stray request. The stray request marks an overrun, while the final accept starts the region reset. The bench provokes this by forcing cfg_ready high on the last word and raising req_valid in that very cycle. It then judges the outcome. The following cycles must show region_rst starting exactly as in an undisturbed swap, with ovr set, and the original target must still be the loaded module afterwards: a repeat request for it must complete as an immediate hit.

// File: rtl/prr_swap_pkg.sv
package prr_swap_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ISOLATE,
    ST_LK_OFF,
    ST_LK_LEN,
    ST_STREAM,
    ST_RESET,
    ST_RELEASE,
    ST_DONE,
    ST_ERROR
  } seq_state_t;
endpackage

// File: rtl/prr_cfg_streamer.sv
module prr_cfg_streamer #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] len_in,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] cnt,
  output logic              last,
  output logic              fin
);
  logic [ADDR_W-1:0] len_q;
  logic              run_d;
  logic [ADDR_W-1:0] cnt_d;
  logic [ADDR_W-1:0] len_d;

  assign valid = run_q_w;
  logic run_q_w;

  assign last = run_q_w && (cnt == len_q - ADDR_W'(1));
  assign fin  = last && ready;

  always_comb begin
    run_d = run_q_w;
    cnt_d = cnt;
    len_d = len_q;
    if (load) begin
      run_d = 1'b1;
      cnt_d = '0;
      len_d = len_in;
    end else if (run_q_w && ready) begin
      cnt_d = cnt + ADDR_W'(1);
      if (fin) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q_w <= 1'b0;
      cnt     <= '0;
      len_q   <= '0;
    end else begin
      run_q_w <= run_d;
      cnt     <= cnt_d;
      len_q   <= len_d;
    end
  end

  // R5: a stalled word keeps the port valid
  p_hold_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid);
endmodule

// File: rtl/prr_rst_timer.sv
module prr_rst_timer #(
  parameter int RST_CYCLES = 16,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_d;

  assign expire = active && (cnt_q == CW'(RST_CYCLES - 1));

  always_comb begin
    act_d = active;
    cnt_d = cnt_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (active) begin
      cnt_d = cnt_q + CW'(1);
      if (expire) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else begin
      active <= act_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6: the reset pulse never exceeds its programmed length
  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !active || start);
endmodule

// File: rtl/prr_swap_seq.sv
module prr_swap_seq
  import prr_swap_pkg::*;
#(
  parameter int                  IDX_W      = 2,
  parameter int                  ADDR_W     = 12,
  parameter int                  DATA_W     = 32,
  parameter int                  RST_CYCLES = 16,
  parameter logic [ADDR_W-1:0]   LUT_BASE   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_module,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [DATA_W-1:0] cfg_data,
  output logic              cfg_last,
  output logic              iso_en,
  output logic              region_rst,
  output logic              up_stall,
  output logic              dn_stall,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ovr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  seq_state_t        st_q, st_d;
  logic [IDX_W-1:0]  tgt_q, tgt_d;
  logic [IDX_W-1:0]  ld_q, ld_d;
  logic              ld_v_q, ld_v_d;
  logic [ADDR_W-1:0] off_q, off_d;
  logic              ovr_d;

  logic              s_load, s_fin;
  logic [ADDR_W-1:0] s_cnt;
  logic              t_act, t_exp;
  logic              accept, len_zero;
  logic [ADDR_W-1:0] entry_addr;

  assign accept     = req_valid && !busy;
  assign len_zero   = (mem_rdata[ADDR_W-1:0] == '0);
  assign entry_addr = LUT_BASE + (ADDR_W'(tgt_q) << 1);
  assign s_load     = (st_q == ST_LK_LEN) && !len_zero;

  prr_cfg_streamer #(.ADDR_W(ADDR_W)) u_stream (
    .clk(clk), .rst_n(rst_n), .load(s_load),
    .len_in(mem_rdata[ADDR_W-1:0]), .ready(cfg_ready),
    .valid(cfg_valid), .cnt(s_cnt), .last(cfg_last), .fin(s_fin)
  );

  prr_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(s_fin),
    .active(t_act), .expire(t_exp)
  );

  // next-state process
  always_comb begin
    st_d   = st_q;
    tgt_d  = tgt_q;
    ld_d   = ld_q;
    ld_v_d = ld_v_q;
    off_d  = off_q;
    ovr_d  = ovr || (req_valid && busy);
    unique case (st_q)
      ST_IDLE, ST_ERROR: begin
        if (accept) begin
          tgt_d = req_module;
          if (ld_v_q && (req_module == ld_q)) begin
            st_d = ST_DONE;
          end else begin
            st_d   = ST_ISOLATE;
            ld_v_d = 1'b0;
          end
        end
      end
      ST_ISOLATE: st_d = ST_LK_OFF;
      ST_LK_OFF: begin
        off_d = mem_rdata[ADDR_W-1:0];
        st_d  = ST_LK_LEN;
      end
      ST_LK_LEN:  st_d = len_zero ? ST_ERROR : ST_STREAM;
      ST_STREAM:  if (s_fin) st_d = ST_RESET;
      ST_RESET:   if (t_exp) st_d = ST_RELEASE;
      ST_RELEASE: begin
        st_d   = ST_DONE;
        ld_d   = tgt_q;
        ld_v_d = 1'b1;
      end
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= '0;
      ld_q   <= '0;
      ld_v_q <= 1'b0;
      off_q  <= '0;
      ovr    <= 1'b0;
    end else begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      ld_q   <= ld_d;
      ld_v_q <= ld_v_d;
      off_q  <= off_d;
      ovr    <= ovr_d;
    end
  end

  // outputs
  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = '0;
    if (st_q == ST_LK_OFF) begin
      mem_rd   = 1'b1;
      mem_addr = entry_addr;
    end else if (st_q == ST_LK_LEN) begin
      mem_rd   = 1'b1;
      mem_addr = entry_addr + ONE;
    end else if (cfg_valid) begin
      mem_rd   = 1'b1;
      mem_addr = LUT_BASE + off_q + s_cnt;
    end
  end

  assign cfg_data   = mem_rdata;
  assign iso_en     = !(st_q inside {ST_IDLE, ST_DONE});
  assign up_stall   = iso_en;
  assign dn_stall   = iso_en;
  assign region_rst = t_act || (st_q == ST_ERROR);
  assign busy       = !(st_q inside {ST_IDLE, ST_ERROR});
  assign done       = (st_q == ST_DONE);
  assign err        = (st_q == ST_ERROR);

  // R5: no configuration word while the boundary is open
  p_iso_before_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> iso_en);
  // R5: stalled word keeps its address
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> $stable(mem_addr));
  // R2: isolation is in place before the first read
  p_iso_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |-> $past(iso_en));
  // R6: the region reset only happens behind the fence
  p_rst_fenced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    region_rst |-> iso_en);
  // R7: the fence opens with completion
  p_open_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> done);
  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: overrun is sticky
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
endmodule

// File: tb/prr_swap_seq_tb.sv
module prr_swap_seq_tb;
  localparam int IDX_W = 2, ADDR_W = 12, DATA_W = 32, RSTC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [IDX_W-1:0] req_module = '0;
  logic mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic cfg_valid, cfg_ready, cfg_last;
  logic [DATA_W-1:0] cfg_data;
  logic iso_en, region_rst, up_stall, dn_stall, busy, done, err, ovr;

  int n_chk = 0, n_bad = 0;
  bit over = 0;
  int loaded = -1;
  int m_off [4] = '{16, 40, 80, 100};
  int m_len [4] = '{5, 12, 1, 0};
  logic [DATA_W-1:0] bmem [256];

  always #4 clk = ~clk;

  assign mem_rdata = bmem[mem_addr[7:0]];

  prr_swap_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .RST_CYCLES(RSTC), .LUT_BASE('0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_module(req_module),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data),
    .cfg_last(cfg_last), .iso_en(iso_en), .region_rst(region_rst),
    .up_stall(up_stall), .dn_stall(dn_stall), .busy(busy), .done(done),
    .err(err), .ovr(ovr));

  function automatic logic [DATA_W-1:0] img_word(int a);
    return 32'hC0DE_0000 ^ (32'(a) * 32'h0001_0101);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // run one swap request for module idx; inj raises a stray request
  // on the final accepted word
  task automatic swap(int idx, bit inj);
    int k;
    bit hit;
    hit = (idx == loaded);
    @(negedge clk);
    req_valid = 1'b1; req_module = IDX_W'(idx);
    @(negedge clk);
    req_valid = 1'b0;
    if (hit) begin
      chk(done == 1'b1, "R8 done", done, 1);
      chk(iso_en == 1'b0 && mem_rd == 1'b0 && region_rst == 1'b0, "R8 quiet",
          {iso_en, mem_rd, region_rst}, 0);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R8 idle", {done, busy}, 0);
      return;
    end
    chk(iso_en && up_stall && dn_stall, "R2 fence", {iso_en, up_stall, dn_stall}, 7);
    chk(mem_rd == 1'b0, "R2 no read yet", mem_rd, 0);
    @(negedge clk);
    chk(mem_rd == 1'b1 && mem_addr == ADDR_W'(2*idx), "R3 offset addr", mem_addr, 2*idx);
    @(negedge clk);
    chk(mem_rd == 1'b1 && mem_addr == ADDR_W'(2*idx+1), "R3 length addr", mem_addr, 2*idx+1);
    @(negedge clk);
    if (m_len[idx] == 0) begin
      chk(err && iso_en && region_rst && !busy && !cfg_valid, "R9 error hold",
          {err, iso_en, region_rst, busy, cfg_valid}, 5'b11100);
      loaded = -1;
      return;
    end
    k = 0;
    while (k < m_len[idx]) begin
      cfg_ready = ($urandom % 3) != 0;
      if (inj && k == m_len[idx]-1) begin
        cfg_ready = 1'b1;
        req_valid = 1'b1;
        req_module = IDX_W'((idx + 1) % 3);
      end
      chk(cfg_valid == 1'b1, "R5 valid held", cfg_valid, 1);
      chk(mem_addr == ADDR_W'(m_off[idx] + k), "R4 address", mem_addr, m_off[idx] + k);
      chk(cfg_data == img_word(m_off[idx] + k), "R4 data", cfg_data, img_word(m_off[idx] + k));
      chk(cfg_last == (k == m_len[idx]-1), "R4 last", cfg_last, (k == m_len[idx]-1));
      chk(region_rst == 1'b0, "R6 no early reset", region_rst, 0);
      @(negedge clk);
      if (cfg_ready) k++;
    end
    cfg_ready = 1'b0;
    req_valid = 1'b0;
    if (inj) chk(ovr == 1'b1, "R10 overrun flagged", ovr, 1);
    for (int r = 0; r < RSTC; r++) begin
      chk(region_rst && iso_en && !cfg_valid, "R6 reset pulse",
          {region_rst, iso_en, cfg_valid}, 3'b110);
      @(negedge clk);
    end
    chk(!region_rst && iso_en && !done, "R6 reset length", {region_rst, iso_en, done}, 3'b010);
    @(negedge clk);
    chk(done && !iso_en && !up_stall && !dn_stall, "R7 open with done",
        {done, iso_en, up_stall, dn_stall}, 4'b1000);
    @(negedge clk);
    chk(!done && !busy, "R7 idle", {done, busy}, 0);
    loaded = idx;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = img_word(i);
    for (int m = 0; m < 4; m++) begin
      bmem[2*m]   = 32'(m_off[m]);
      bmem[2*m+1] = 32'hFFFF_0000 & 32'(0) | 32'(m_len[m]);
    end
    cfg_ready = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!iso_en && !region_rst && !up_stall && !dn_stall && !busy && !done
        && !err && !ovr && !cfg_valid && !mem_rd, "R1 reset state",
        {iso_en, region_rst, busy, done, err, ovr, cfg_valid, mem_rd}, 0);
    swap(0, 0);
    swap(0, 0);
    chk(ovr == 1'b0, "R10 no spurious overrun", ovr, 0);
    swap(1, 1);
    swap(1, 0);
    chk(ovr == 1'b1, "R10 overrun sticky", ovr, 1);
    swap(2, 0);
    swap(3, 0);
    swap(3, 0);
    swap(2, 0);
    for (int n = 0; n < 8; n++) swap(int'($urandom % 4), ($urandom % 2) == 1);
    over = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!over) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule